// File: doc/BRIEF.md
# Resolver Signal Degradation Monitor

The block watches digitized resolver channels for a degrading signal. On each cycle with a valid strobe it accepts a signed sine sample, a signed cosine sample and an unsigned magnitude-squared monitor value. It drives an active-low degradation flag that a downstream fault handler reads next to the position data.

There are two causes. An overrange cause follows the channels: it is set while the latest accepted sample has either channel magnitude above a configured limit, and it drops as soon as an accepted sample is back in range. A mismatch cause comes from running minimum and maximum registers of the monitor value. When their spread exceeds a configured threshold, the cause is latched. A rising edge on the sample input clears the latch and restarts the tracking from the monitor value present in that cycle. A two-bit cause output shows which cause is active.

Top module: `resolver_dos_monitor`

## Requirements
- R1: After reset, dos_no is 1 and cause_o is 0. The min/max registers start out empty, so the first sample taken loads both of them.
- R2: The magnitude of a sample is its absolute value as a two's-complement number, so -2^(SW-1) has magnitude 2^(SW-1). A cycle with valid_i=1 in which the sine or cosine magnitude is strictly above ovr_thr_i sets cause_o[0] to 1 on the next clock edge. A magnitude equal to ovr_thr_i does not set it.
- R3: cause_o[0] is not latched. The next valid sample with both magnitudes at or below ovr_thr_i clears it on the following edge. Cycles with valid_i=0 leave it unchanged.
- R4: The block takes monitor values from cycles with valid_i=1 since the last clear and tracks their minimum and maximum. Once max-min is strictly greater than mis_thr_i, cause_o[1] becomes 1 two clock edges after the sample that widened the spread. A spread equal to mis_thr_i does not set it.
- R5: cause_o[1] stays 1 whatever samples follow, until a rising edge of sample_i. That edge clears cause_o[1] at the clock edge where sample_i is first seen high.
- R6: A rising edge of sample_i loads both the minimum and the maximum with the mon_i of that cycle, whatever the value of valid_i. Holding sample_i high causes no further clear, so a mismatch that builds while sample_i stays high latches again.
- R7: dos_no is 0 exactly when at least one bit of cause_o is 1. Bit 0 is overrange and bit 1 is mismatch.
- R8: In a cycle with valid_i=0, mon_i, sin_i and cos_i have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample strobe for sin_i, cos_i, mon_i |
| sample_i | input | 1 | Rising edge clears the mismatch latch and restarts min/max |
| sin_i | input | SW | Sine sample, two's complement |
| cos_i | input | SW | Cosine sample, two's complement |
| mon_i | input | MW | Monitor magnitude, unsigned |
| ovr_thr_i | input | SW | Overrange magnitude limit, unsigned |
| mis_thr_i | input | MW | Mismatch spread limit, unsigned |
| dos_no | output | 1 | Degradation flag, active low |
| cause_o | output | 2 | Bit 0 overrange, bit 1 mismatch |

## Verification
Two situations are hard to reach from the ports. The first is a mismatch that builds up again while sample_i is held high after its edge. The second is a rising edge of sample_i arriving in the same cycle as a spread that would set the latch. Neither happens often under random stimulus, so directed phases hold sample_i high across a widening spread, and they raise sample_i in the cycle after an out-of-band monitor value. Random phases add short sample pulses and invalid cycles that carry extreme monitor and channel values. Boundary phases place the channel magnitude and the spread exactly at, and one above, their thresholds, and include the most negative channel code.

// File: rtl/rdm_pkg.sv
package rdm_pkg;
  localparam int CH_NUM = 2;

  typedef struct packed {
    logic mis;
    logic ovr;
  } rdm_cause_t;
endpackage

// File: rtl/rdm_overrange.sv
module rdm_overrange #(
  parameter int SW = 16,
  parameter int CN = rdm_pkg::CH_NUM
) (
  input  logic [CN-1:0][SW-1:0] smp_i,
  input  logic [SW-1:0]         thr_i,
  output logic                  over_o
);
  logic [CN-1:0] hit;

  for (genvar ch = 0; ch < CN; ch++) begin : g_ch
    logic [SW-1:0] mag;
    // SW-bit unsigned magnitude; most negative code maps to 2^(SW-1)
    assign mag     = smp_i[ch][SW-1] ? (~smp_i[ch] + 1'b1) : smp_i[ch];
    assign hit[ch] = mag > thr_i;
  end

  assign over_o = |hit;
endmodule

// File: rtl/rdm_edge.sv
module rdm_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;

  assert_single_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/rdm_minmax.sv
module rdm_minmax #(
  parameter int MW = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          restart_i,
  input  logic [MW-1:0] mon_i,
  output logic          have_o,
  output logic [MW-1:0] min_o,
  output logic [MW-1:0] max_o
);
  logic          have_q;
  logic [MW-1:0] min_q, max_q;
  logic          load;

  assign load = restart_i | (valid_i & ~have_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q <= 1'b0;
      min_q  <= '0;
      max_q  <= '0;
    end else if (load) begin
      have_q <= 1'b1;
      min_q  <= mon_i;
      max_q  <= mon_i;
    end else if (valid_i) begin
      if (mon_i < min_q) min_q <= mon_i;
      if (mon_i > max_q) max_q <= mon_i;
    end
  end

  assign have_o = have_q;
  assign min_o  = min_q;
  assign max_o  = max_q;

  assert_min_le_max_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    have_q |-> (min_q <= max_q));

  assert_restart_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (min_q == $past(mon_i)) && (max_q == $past(mon_i)));

  assert_min_monotone_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (have_q && !restart_i) |=> (min_q <= $past(min_q)) && (max_q >= $past(max_q)));

  assert_invalid_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !restart_i) |=> $stable(min_q) && $stable(max_q));
endmodule

// File: rtl/resolver_dos_monitor.sv
module resolver_dos_monitor #(
  parameter int SW = 16,
  parameter int MW = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          sample_i,
  input  logic [SW-1:0] sin_i,
  input  logic [SW-1:0] cos_i,
  input  logic [MW-1:0] mon_i,
  input  logic [SW-1:0] ovr_thr_i,
  input  logic [MW-1:0] mis_thr_i,
  output logic          dos_no,
  output logic [1:0]    cause_o
);
  import rdm_pkg::*;

  logic                     rise;
  logic                     over_now;
  logic                     have;
  logic [MW-1:0]            mn, mx;
  logic                     mis_now;
  logic [CH_NUM-1:0][SW-1:0] chans;
  rdm_cause_t               cause_q;

  assign chans = {cos_i, sin_i};

  rdm_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (sample_i),
    .rise_o (rise)
  );

  rdm_overrange #(.SW(SW), .CN(CH_NUM)) u_ovr (
    .smp_i  (chans),
    .thr_i  (ovr_thr_i),
    .over_o (over_now)
  );

  rdm_minmax #(.MW(MW)) u_mm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .restart_i (rise),
    .mon_i     (mon_i),
    .have_o    (have),
    .min_o     (mn),
    .max_o     (mx)
  );

  assign mis_now = have & ((mx - mn) > mis_thr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= '0;
    end else begin
      if (valid_i) cause_q.ovr <= over_now;
      // clear on edge wins over a spread seen in the same cycle
      if (rise)         cause_q.mis <= 1'b0;
      else if (mis_now) cause_q.mis <= 1'b1;
    end
  end

  assign cause_o = cause_q;
  assign dos_no  = ~(cause_q.mis | cause_q.ovr);

  assert_ovr_follow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && over_now) |=> cause_o[0]);

  assert_ovr_release_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !over_now) |=> !cause_o[0]);

  assert_ovr_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(cause_o[0]));

  assert_mis_latched_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_o[1] && !rise) |=> cause_o[1]);

  assert_mis_cleared_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> !cause_o[1]);

  assert_flag_polarity_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cause_o[1]) |-> !dos_no);
endmodule

// File: tb/resolver_dos_monitor_test.sv
module resolver_dos_monitor_test;
  localparam int SW = 16;
  localparam int MW = 20;
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic          sample_i = 1'b0;
  logic [SW-1:0] sin_i = '0;
  logic [SW-1:0] cos_i = '0;
  logic [MW-1:0] mon_i = '0;
  logic [SW-1:0] ovr_thr_i = '0;
  logic [MW-1:0] mis_thr_i = '0;
  logic          dos_no;
  logic [1:0]    cause_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // reference state, built from the requirements
  bit m_have, m_ovr, m_mis, m_prev_s;
  int m_min, m_max;

  always #(CLK_PERIOD/2) clk = ~clk;

  resolver_dos_monitor #(.SW(SW), .MW(MW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .sample_i(sample_i),
    .sin_i(sin_i), .cos_i(cos_i), .mon_i(mon_i), .ovr_thr_i(ovr_thr_i),
    .mis_thr_i(mis_thr_i), .dos_no(dos_no), .cause_o(cause_o)
  );

  function automatic int mag(input logic [SW-1:0] v);
    int s = $signed(v);
    return (s < 0) ? -s : s;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input bit v, input bit s, input int sn, input int cs,
                      input int mn, input string tag_o, input string tag_m);
    bit edge_s, nm;
    @(negedge clk);
    valid_i = v; sample_i = s;
    sin_i = SW'(sn); cos_i = SW'(cs); mon_i = MW'(mn);
    @(posedge clk);
    edge_s   = s && !m_prev_s;
    m_prev_s = s;
    nm = edge_s ? 1'b0 : (m_mis || (m_have && (m_max - m_min > int'(mis_thr_i))));
    if (edge_s || (v && !m_have)) begin
      m_have = 1'b1; m_min = mn; m_max = mn;
    end else if (v) begin
      if (mn < m_min) m_min = mn;
      if (mn > m_max) m_max = mn;
    end
    if (v) m_ovr = (mag(SW'(sn)) > int'(ovr_thr_i)) || (mag(SW'(cs)) > int'(ovr_thr_i));
    m_mis = nm;
    #1;
    check(tag_o, "cause_o[0]", int'(cause_o[0]), int'(m_ovr));
    check(tag_m, "cause_o[1]", int'(cause_o[1]), int'(m_mis));
    check("R7", "dos_no", int'(dos_no), int'(!(m_ovr || m_mis)));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    ovr_thr_i = 16'd20000;
    mis_thr_i = 20'd3000;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "dos_no", int'(dos_no), 1);
    check("R1", "cause_o", int'(cause_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    m_have = 0; m_ovr = 0; m_mis = 0; m_prev_s = 0; m_min = 0; m_max = 0;

    // R1: first sample loads both registers, spread zero
    step(1, 0, 100, 100, 50000, "R1", "R1");
    step(0, 0, 0, 0, 0, "R1", "R1");
    // R2 boundaries
    step(1, 0, 20000, 0, 50000, "R2", "R4");
    step(1, 0, 20001, 0, 50000, "R2", "R4");
    step(1, 0, 0, -20000, 50000, "R3", "R4");
    step(1, 0, 0, -20001, 50000, "R2", "R4");
    ovr_thr_i = 16'd32767;
    step(1, 0, -32768, 0, 50000, "R2", "R4");
    step(0, 0, 0, 0, 50000, "R3", "R4");
    step(1, 0, 32767, -32767, 50000, "R3", "R4");
    ovr_thr_i = 16'd20000;
    // R4 boundary: spread equal to threshold, then one above
    step(1, 0, 0, 0, 53000, "R3", "R4");
    step(1, 0, 0, 0, 51000, "R3", "R4");
    step(0, 0, 0, 0, 0, "R3", "R4");
    step(1, 0, 0, 0, 49999, "R3", "R4");
    step(1, 0, 0, 0, 50000, "R3", "R4");
    step(1, 0, 0, 0, 50000, "R3", "R5");
    // R5: latched through in-range samples
    repeat (4) step(1, 0, 10, 10, 50000, "R3", "R5");
    step(1, 1, 10, 10, 50000, "R3", "R5");
    // R6: held high, spread grows again and latches
    step(1, 1, 10, 10, 60000, "R3", "R6");
    step(1, 1, 10, 10, 60000, "R3", "R6");
    repeat (3) step(1, 1, 10, 10, 60000, "R3", "R6");
    step(1, 0, 10, 10, 60000, "R3", "R6");
    // R6: edge in the cycle after an out-of-band value, edge without valid
    step(1, 0, 10, 10, 90000, "R3", "R6");
    step(0, 1, 0, 0, 70000, "R3", "R6");
    step(1, 0, 0, 0, 72000, "R3", "R6");
    step(1, 0, 0, 0, 68000, "R3", "R6");
    step(0, 0, 0, 0, 0, "R3", "R6");
    // R8: invalid cycles carry extreme values
    step(1, 1, 0, 0, 40000, "R8", "R8");
    step(1, 0, 0, 0, 40000, "R8", "R8");
    repeat (6) step(0, 0, -32768, 32767, 1048575, "R8", "R8");
    step(0, 0, 30000, 0, 0, "R8", "R8");
    step(1, 0, 0, 0, 40000, "R8", "R8");
    step(1, 0, 0, 0, 40000, "R8", "R8");

    // random phases
    for (int ph = 0; ph < 4; ph++) begin
      ovr_thr_i = SW'(15000 + ph * 5000);
      mis_thr_i = MW'(1000 + ph * 1500);
      for (int i = 0; i < 2000; i++) begin
        int base, sn, cs, mn;
        bit v, s;
        base = int'(ovr_thr_i);
        v  = ($urandom_range(0, 9) != 0);
        s  = ($urandom_range(0, 15) == 0) ? ~sample_i : sample_i;
        sn = $urandom_range(0, 2) == 0 ? int'($urandom_range(0, 65535)) - 32768
                                       : int'($urandom_range(0, 2*base + 40)) - base - 20;
        cs = int'($urandom_range(0, 2*base + 40)) - base - 20;
        mn = 400000 + int'($urandom_range(0, 2 * int'(mis_thr_i) / 3));
        if ($urandom_range(0, 63) == 0) mn = int'($urandom_range(0, 1048575));
        step(v, s, sn, cs, mn, "R2", "R5");
      end
    end
    finish_run();
  end
endmodule